// File: doc/BRIEF.md
# Transmit-Only Display-ID Streamer

This block streams the contents of a 128-byte display-identification memory on a two-wire data line with no command from a host, paced only by a dedicated output clock. After reset it sits in transmit-only mode. Once it has counted a short warm-up on that clock, it sends the array byte by byte from address 00h upward. Each byte takes nine clock periods: eight data bits, most significant first, then one released "null" slot. After the top address it starts again at 00h, so a host can pick up the whole array with nothing but a clock.

A falling edge on the two-wire clock line moves the block into a transitional bidirectional state, provided the block is not holding the data line low at that moment. In that state a watchdog counts output-clock edges. If 128 edges pass with no acknowledged command, the block goes back to streaming. If the command engine reports an acknowledged command first, the block stays in bidirectional mode until reset. While the block is bidirectional, the output-clock pin acts as a write-enable level for the command engine and gates writes into the array. All external lines are resynchronised into the system clock domain, and their edges are found by comparing registered samples.

Top module: `dispIdStreamer`

## Requirements
- R1: After reset the block is in transmit-only mode. `sdaPullLow` is 0, `bidirMode` is 0, `writeEnable` is 0 and `readAddr` is 00h.
- R2: After reset the data line stays released for the first 9 rising `vclkIn` edges. On the 10th rising edge the block presents bit 7 of address 00h.
- R3: Each byte is sent most significant bit first, one bit per rising `vclkIn` edge. A 0 bit drives `sdaPullLow`=1 and a 1 bit releases the line (`sdaPullLow`=0). The ninth slot is always released. `readAddr` shows the byte being sent and advances by one every 9 rising edges.
- R4: After the byte at address 7Fh, the next byte sent is the one at address 00h.
- R5: In transmit-only mode, a falling edge on `sclIn` while the line is released switches the block to the transitional bidirectional state (`bidirMode`=1) and stops the stream. A falling edge on `sclIn` while the block pulls the line low is ignored.
- R6: In the transitional state, the 128th rising `vclkIn` edge with no acknowledge returns the block to transmit-only mode (`bidirMode`=0, line released). The 129th rising edge presents bit 7 of address 00h.
- R7: In the transitional state, each falling edge on `sclIn` restarts the 128-edge count from zero.
- R8: A `cmdAckIn` pulse in the transitional state locks bidirectional mode. No number of `vclkIn` edges returns the block to transmit-only mode until reset.
- R9: `writeEnable` follows the synchronised `vclkIn` level while `bidirMode` is 1 and is 0 in transmit-only mode.
- R10: A write from the command engine changes the array only while `bidirMode` is 1 and the synchronised `vclkIn` is high. Array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| vclkIn | input | 1 | Output clock for streaming; write-enable level in bidirectional mode (asynchronous) |
| sclIn | input | 1 | Two-wire clock line as sampled from the pad (asynchronous) |
| cmdAckIn | input | 1 | Pulse from the command engine: a valid command was acknowledged |
| memWrEn | input | 1 | Array write strobe from the command engine |
| memWrAddr | input | 7 | Array write address |
| memWrData | input | 8 | Array write data |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |
| readAddr | output | 7 | Address of the byte currently being streamed |
| bidirMode | output | 1 | 1 while in the transitional or locked bidirectional state |
| writeEnable | output | 1 | Synchronised `vclkIn` level passed to the command engine in bidirectional mode |

## Verification
The in-line assertions check on every cycle the things that can be seen from one cycle to the next: the address holds within a byte and wraps from the top, the line stays released while the warm-up count runs, a released clock-line fall enters the transitional state, the watchdog's final edge returns to streaming, and the locked state never leaves. The bench scenarios cover what needs long runs or memory contents. These are the exact bit sequence of streamed bytes across a full 1152-edge wrap, the 10th-edge and 129th-edge start points, the watchdog restart on a second clock-line fall, writes rejected while `vclkIn` is low or in transmit-only mode, and array contents kept across reset.

// File: rtl/idStreamPkg.sv
package idStreamPkg;

  typedef enum logic [1:0] {
    MODE_TX    = 2'd0,
    MODE_TRANS = 2'd1,
    MODE_LOCK  = 2'd2
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // one output-clock step in transmit-only mode
    logic halt;     // stop streaming, release the line
    logic resume;   // watchdog fallback: next step starts byte 00h
    logic wrAllow;  // array writes permitted this cycle
  } strobeT;

endpackage

// File: rtl/lineSync.sv
module lineSync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= rawIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], rawIn};
      end
    end
  endgenerate

  assign level = chain[STAGES-1];

endmodule

// File: rtl/modeCtrl.sv
module modeCtrl
  import idStreamPkg::*;
#(
  parameter int WD_LIMIT = 128
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   vclkLevel,
  input  logic   sclLevel,
  input  logic   cmdAck,
  input  logic   sdaPullLow,
  output strobeT ctl,
  output logic   bidirMode,
  output logic   writeEnable
);

  localparam int WD_W = $clog2(WD_LIMIT);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_LIMIT - 1);

  modeT            mode;
  logic [WD_W-1:0] wdCnt;
  logic            vclkPrev, sclPrev;
  logic            vclkRise, sclFall;
  logic            enterTrans, fallBack;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vclkPrev <= 1'b0;
      sclPrev  <= 1'b1;
    end else begin
      vclkPrev <= vclkLevel;
      sclPrev  <= sclLevel;
    end
  end

  assign vclkRise = vclkLevel & ~vclkPrev;
  assign sclFall  = ~sclLevel & sclPrev;

  assign enterTrans = (mode == MODE_TX) && sclFall && !sdaPullLow;
  assign fallBack   = (mode == MODE_TRANS) && !cmdAck && !sclFall &&
                      vclkRise && (wdCnt == WD_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode  <= MODE_TX;
      wdCnt <= '0;
    end else begin
      unique case (mode)
        MODE_TX: begin
          if (enterTrans) begin
            mode  <= MODE_TRANS;
            wdCnt <= '0;
          end
        end
        MODE_TRANS: begin
          if (cmdAck) begin
            mode <= MODE_LOCK;
          end else if (sclFall) begin
            wdCnt <= '0;
          end else if (vclkRise) begin
            if (wdCnt == WD_LAST) begin
              mode  <= MODE_TX;
              wdCnt <= '0;
            end else begin
              wdCnt <= wdCnt + 1'b1;
            end
          end
        end
        default: mode <= MODE_LOCK;
      endcase
    end
  end

  always_comb begin
    ctl.advance = (mode == MODE_TX) && vclkRise && !enterTrans;
    ctl.halt    = enterTrans;
    ctl.resume  = fallBack;
    ctl.wrAllow = (mode != MODE_TX) && vclkLevel;
  end

  assign bidirMode   = (mode != MODE_TX);
  assign writeEnable = bidirMode & vclkLevel;

  // R5: a released clock-line fall in streaming mode enters the transitional state
  assert_enter_trans_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TX && sclFall && !sdaPullLow) |=> (mode == MODE_TRANS));

  // R6: final watchdog edge without acknowledge returns to streaming
  assert_watchdog_fallback_R6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TRANS && vclkRise && wdCnt == WD_LAST && !sclFall && !cmdAck)
      |=> (mode == MODE_TX));

  // R7: a clock-line fall in the transitional state clears the watchdog
  assert_wd_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TRANS && sclFall && !cmdAck) |=> (wdCnt == '0));

  // R8: the locked state is never left
  assert_lock_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LOCK) |=> (mode == MODE_LOCK));

endmodule

// File: rtl/streamDp.sv
module streamDp
  import idStreamPkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int PRIME_LEN = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            ctl,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              sdaPullLow,
  output logic [ADDR_W-1:0] readAddr
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PRIME_W = $clog2(PRIME_LEN + 1);
  localparam int BIT_W   = $clog2(DATA_W + 1);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam logic [PRIME_W-1:0] PRIME_DONE = PRIME_W'(PRIME_LEN);
  localparam logic [BIT_W-1:0]   NULL_SLOT  = BIT_W'(DATA_W);

  logic [DATA_W-1:0]  mem [DEPTH];
  logic               active;
  logic [PRIME_W-1:0] primeCnt;
  logic [BIT_W-1:0]   bitPos;
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  curByte;
  logic [IDX_W-1:0]   bitSel;
  logic               outBit;

  // array keeps its contents across reset
  always_ff @(posedge clk) begin
    if (ctl.wrAllow && wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      primeCnt <= '0;
      bitPos   <= '0;
      addr     <= '0;
    end else if (ctl.halt) begin
      active <= 1'b0;
    end else if (ctl.resume) begin
      active   <= 1'b0;
      primeCnt <= PRIME_DONE;
      bitPos   <= '0;
      addr     <= '0;
    end else if (ctl.advance) begin
      if (!active) begin
        if (primeCnt == PRIME_DONE) begin
          active <= 1'b1;
          bitPos <= '0;
          addr   <= '0;
        end else begin
          primeCnt <= primeCnt + 1'b1;
        end
      end else if (bitPos == NULL_SLOT) begin
        bitPos <= '0;
        addr   <= addr + 1'b1;
      end else begin
        bitPos <= bitPos + 1'b1;
      end
    end
  end

  assign curByte = mem[addr];
  assign bitSel  = IDX_W'(DATA_W - 1) - bitPos[IDX_W-1:0];

  always_comb begin
    if (bitPos == NULL_SLOT) outBit = 1'b1;
    else                     outBit = curByte[bitSel];
  end

  assign sdaPullLow = active & ~outBit;
  assign readAddr   = addr;

  // R2: while the warm-up count runs the line stays released
  assert_prime_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !active && primeCnt != PRIME_DONE) |=> !sdaPullLow);

  // R3: the address holds inside a byte
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.halt && active && bitPos != NULL_SLOT) |=> $stable(readAddr));

  // R4: top address wraps to zero after its null slot
  assert_addr_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.halt && active && bitPos == NULL_SLOT && addr == {ADDR_W{1'b1}})
      |=> (readAddr == '0));

  // R5: after a halt the line is released
  assert_halt_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.halt |=> !sdaPullLow);

endmodule

// File: rtl/dispIdStreamer.sv
module dispIdStreamer
  import idStreamPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PRIME_LEN   = 9,
  parameter int WD_LIMIT    = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vclkIn,
  input  logic              sclIn,
  input  logic              cmdAckIn,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  output logic              sdaPullLow,
  output logic [ADDR_W-1:0] readAddr,
  output logic              bidirMode,
  output logic              writeEnable
);

  logic   vclkLevel, sclLevel;
  strobeT ctl;

  lineSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_vclkSync (
    .clk(clk), .rstN(rstN), .rawIn(vclkIn), .level(vclkLevel)
  );

  lineSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .rawIn(sclIn), .level(sclLevel)
  );

  modeCtrl #(.WD_LIMIT(WD_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .vclkLevel(vclkLevel), .sclLevel(sclLevel), .cmdAck(cmdAckIn),
    .sdaPullLow(sdaPullLow), .ctl(ctl),
    .bidirMode(bidirMode), .writeEnable(writeEnable)
  );

  streamDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIME_LEN(PRIME_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrEn(memWrEn), .wrAddr(memWrAddr), .wrData(memWrData),
    .sdaPullLow(sdaPullLow), .readAddr(readAddr)
  );

  // R9: in streaming mode the write-enable output is never raised
  assert_we_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !bidirMode |-> !writeEnable);

endmodule

// File: tb/dispIdStreamer_bench.sv
module dispIdStreamer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vclkIn = 1'b0;
  logic       sclIn = 1'b1;
  logic       cmdAckIn = 1'b0;
  logic       memWrEn = 1'b0;
  logic [6:0] memWrAddr = '0;
  logic [7:0] memWrData = '0;
  logic       sdaPullLow;
  logic [6:0] readAddr;
  logic       bidirMode;
  logic       writeEnable;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // model of the streaming sequence, taken from R2, R3, R4 and R6
  bit mActive;
  int mPrime, mBit, mAddr;

  always #4 clk = ~clk;  // 125 MHz

  dispIdStreamer u_dispIdStreamer (
    .clk(clk), .rstN(rstN), .vclkIn(vclkIn), .sclIn(sclIn), .cmdAckIn(cmdAckIn),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .sdaPullLow(sdaPullLow), .readAddr(readAddr),
    .bidirMode(bidirMode), .writeEnable(writeEnable)
  );

  // main run: pulses to issue, then the expected byte address
  localparam int         RUN_STEPS [6] = '{1, 9, 8, 1, 1125, 9};
  localparam logic [6:0] RUN_ADDR  [6] = '{7'h00, 7'h01, 7'h01, 7'h02, 7'h7F, 7'h00};

  function automatic logic [7:0] patByte(int a);
    return 8'((a * 37 + 60) & 255);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic modelReset();
    mActive = 0; mPrime = 0; mBit = 0; mAddr = 0;
  endtask

  task automatic modelStep();
    if (!mActive) begin
      if (mPrime == 9) begin mActive = 1; mBit = 0; mAddr = 0; end
      else mPrime++;
    end else if (mBit == 8) begin
      mBit = 0; mAddr = (mAddr + 1) % 128;
    end else mBit++;
  endtask

  function automatic bit expPull();
    logic [7:0] b;
    b = patByte(mAddr);
    if (!mActive || mBit == 8) return 0;
    return !b[7 - mBit];
  endfunction

  task automatic vclkPulse(bit doWr, logic [6:0] a, logic [7:0] d);
    vclkIn = 1'b1;
    waitClk(2);
    if (doWr) begin
      memWrEn = 1'b1; memWrAddr = a; memWrData = d;
      waitClk(1);
      memWrEn = 1'b0;
      waitClk(1);
    end else waitClk(2);
    vclkIn = 1'b0;
    waitClk(4);
  endtask

  task automatic txPulseCheck(string req, bit doWr, logic [6:0] a, logic [7:0] d);
    vclkPulse(doWr, a, d);
    modelStep();
    check(req, "sdaPullLow", int'(sdaPullLow), int'(expPull()));
    if (mActive) check(req, "readAddr", int'(readAddr), mAddr);
  endtask

  task automatic sclDrop();
    sclIn = 1'b0; waitClk(4);
    sclIn = 1'b1; waitClk(4);
  endtask

  task automatic doReset();
    rstN = 1'b0; waitClk(4);
    rstN = 1'b1; waitClk(2);
    modelReset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitClk(2);
    doReset();

    // R1: reset state
    check("R1", "sdaPullLow", int'(sdaPullLow), 0);
    check("R1", "bidirMode", int'(bidirMode), 0);
    check("R1", "writeEnable", int'(writeEnable), 0);
    check("R1", "readAddr", int'(readAddr), 0);

    // R9: no write enable in streaming mode even with vclk high
    vclkIn = 1'b1; waitClk(4);
    check("R9", "writeEnable tx", int'(writeEnable), 0);
    vclkIn = 1'b0; waitClk(4);
    modelStep();

    // R5: released fall enters transitional state
    sclDrop();
    check("R5", "bidirMode enter", int'(bidirMode), 1);
    check("R5", "sdaPullLow enter", int'(sdaPullLow), 0);

    // fill the array while vclk is high (watchdog edge 1)
    vclkIn = 1'b1; waitClk(4);
    check("R9", "writeEnable high", int'(writeEnable), 1);
    for (int a = 0; a < 128; a++) begin
      memWrEn = 1'b1; memWrAddr = 7'(a); memWrData = patByte(a);
      waitClk(1);
    end
    memWrEn = 1'b0;
    vclkIn = 1'b0; waitClk(4);
    check("R9", "writeEnable low", int'(writeEnable), 0);
    // R10: write with vclk low must be dropped
    memWrEn = 1'b1; memWrAddr = 7'd5; memWrData = ~patByte(5);
    waitClk(1);
    memWrEn = 1'b0;

    // watchdog edges 2..127
    for (int i = 0; i < 126; i++) vclkPulse(0, '0, '0);
    check("R6", "bidirMode at 127", int'(bidirMode), 1);
    // R7: restart the count, then 127 edges keep the state
    sclDrop();
    for (int i = 0; i < 127; i++) vclkPulse(0, '0, '0);
    check("R7", "bidirMode after restart", int'(bidirMode), 1);
    vclkPulse(0, '0, '0);
    check("R6", "bidirMode at 128", int'(bidirMode), 0);
    check("R6", "sdaPullLow at 128", int'(sdaPullLow), 0);
    mActive = 0; mPrime = 9; mBit = 0; mAddr = 0;

    // table-driven streaming run through a full wrap
    for (int v = 0; v < 6; v++) begin
      for (int p = 0; p < RUN_STEPS[v]; p++)
        txPulseCheck((mAddr == 5) ? "R10" : ((v < 4) ? "R3" : "R4"), 0, '0, '0);
      check((v < 4) ? "R3" : "R4", "readAddr table", int'(readAddr), int'(RUN_ADDR[v]));
      if (v == 0) check("R6", "129th edge bit7", int'(sdaPullLow), 1);
    end

    // R5: fall while driving low is ignored; R10: write in streaming mode dropped
    sclDrop();
    check("R5", "bidirMode ignored fall", int'(bidirMode), 0);
    txPulseCheck("R5", 1, 7'd1, ~patByte(1));
    check("R5", "still streaming", int'(bidirMode), 0);

    // R2 / R10: restart after reset, array kept
    doReset();
    check("R1", "readAddr after reset", int'(readAddr), 0);
    for (int p = 0; p < 9; p++) txPulseCheck("R2", 0, '0, '0);
    txPulseCheck("R2", 0, '0, '0);
    check("R2", "10th edge bit7", int'(sdaPullLow), 1);
    for (int p = 0; p < 17; p++) txPulseCheck("R10", 0, '0, '0);
    check("R3", "null slot released", int'(sdaPullLow), 0);

    // R8: lock by acknowledge
    sclDrop();
    check("R5", "bidirMode second entry", int'(bidirMode), 1);
    cmdAckIn = 1'b1; waitClk(1); cmdAckIn = 1'b0;
    for (int i = 0; i < 200; i++) vclkPulse(0, '0, '0);
    check("R8", "bidirMode locked", int'(bidirMode), 1);
    check("R8", "sdaPullLow locked", int'(sdaPullLow), 0);
    vclkIn = 1'b1; waitClk(4);
    check("R9", "writeEnable locked high", int'(writeEnable), 1);
    vclkIn = 1'b0; waitClk(4);
    check("R9", "writeEnable locked low", int'(writeEnable), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule